// File: doc/BRIEF.md
# Multi-Rail Soft-Start Power-Up Sequencer

This block is the digital controller that brings up a display bias supply with several rails. It takes a supply-good level (the undervoltage comparator output, hysteresis already applied), a reference-good flag, a latched-fault flag and a switch-select control. When supply and reference are both good, it enables the boost, gate-on and gate-off regulators in one cycle. It then drives a 7-bit soft-start code to each regulator's DAC. The boost and gate-on codes rise from zero to full scale. The gate-off code falls from full scale to a floor of 26, which stands for 250 mV of a 1.25 V reference. Each ramp has its own step period, taken from the clock rate and the ramp duration. Once every ramp has finished, a startup-delay counter runs. When it expires, the switch stage is released and connects the common node to one of two sources, as chosen by the select input.

The controller has five states. ST_OFF waits for supply-good, reference-good and no fault, then moves to ST_RAMP. ST_RAMP advances the three ramps and moves to ST_DELAY when all of them are done. ST_DELAY counts the startup delay and moves to ST_RUN when the count expires. ST_RUN holds the switch stage on. A latched fault in ST_RAMP, ST_DELAY or ST_RUN moves the controller to ST_FAULT. ST_FAULT holds every enable low and freezes the sequence. Loss of supply-good in any state returns the controller to ST_OFF. That is the only way out of ST_FAULT.

The amplifier high-impedance request is asserted in ST_OFF and in ST_FAULT.

Top module: `softstart_sequencer`

## Requirements
- R1: A start (ST_OFF to ST_RAMP) happens only at a clock edge where supply_ok=1, ref_ok=1 and fault_latched=0. With any of these not met, all enables stay 0.
- R2: boost_en, gon_en and goff_en assert in the same cycle. In that first cycle the codes are boost_code=0, gon_code=0 and goff_code=127. Whenever the enables are low, the codes show 0, 0 and 127.
- R3: Each ramp has 128 steps. After n clock edges in ST_RAMP, ramp i has the step index k=min(128, floor(n/STEP_i)). The up codes boost_code and gon_code equal min(k,127).
- R4: goff_code equals 127 - floor(101*k/128). It never goes below 26 and reaches 26 at k=128.
- R5: STEP_i = CLK_KHZ*MS_i/128 cycles, where MS_i is 10 for the boost ramp and 3 for the gate-on and gate-off ramps.
- R6: The controller enters ST_DELAY only after all three ramps reach k=128. sw_enable rises DELAY_CYC clock edges after ST_DELAY is entered.
- R7: When sw_enable=1, com_to_a follows sw_sel and com_to_b follows its inverse. When sw_enable=0, both are 0.
- R8: One edge after supply_ok=0 is sampled, all enables and sw_enable are 0 and amp_hiz is 1. The delay count then restarts from zero on the next start.
- R9: ss_active is 1 exactly while in ST_RAMP, from the first enabled cycle until the cycle after the last ramp completes.
- R10: One edge after fault_latched=1 is sampled, all enables and sw_enable are 0 and amp_hiz is 1. Clearing the fault does not restart the sequence. Only a fall and a new rise of supply_ok does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply-good level from the UVLO comparator |
| ref_ok | input | 1 | Reference is above its good threshold |
| fault_latched | input | 1 | Fault latch is set |
| sw_sel | input | 1 | Switch-select control for the common node |
| boost_en | output | 1 | Boost regulator enable |
| gon_en | output | 1 | Gate-on regulator enable |
| goff_en | output | 1 | Gate-off regulator enable |
| boost_code | output | 7 | Boost soft-start code |
| gon_code | output | 7 | Gate-on soft-start code |
| goff_code | output | 7 | Gate-off soft-start code (descending) |
| ss_active | output | 1 | Soft-start ramps in progress |
| sw_enable | output | 1 | Switch stage released |
| com_to_a | output | 1 | Common node connected to source A |
| com_to_b | output | 1 | Common node connected to source B |
| amp_hiz | output | 1 | Amplifier high-impedance request |

## Verification
The hardest case to reach is a supply drop partway through ST_DELAY. A wrong design that kept its delay count would show up only as an early sw_enable on the next start. To reach it, the stimulus first lets a full ramp finish, then drops supply_ok a few cycles into the delay, then restarts. The reference model then requires the full ramp and the full delay again.

A fault that clears while supply stays good is handled the same way. The stimulus holds supply_ok high for many cycles after the fault clears, so that any self-restart would be visible before the supply is cycled.

// File: rtl/ss_seq_pkg.sv
package ss_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_RAMP  = 3'd1,
        ST_DELAY = 3'd2,
        ST_RUN   = 3'd3,
        ST_FAULT = 3'd4
    } seq_state_t;

    localparam int NUM_RAMPS = 3;

endpackage

// File: rtl/ss_ramp.sv
module ss_ramp #(
    parameter int CODE_W   = 7,
    parameter int STEP_CYC = 10,
    parameter bit DESCEND  = 1'b0,
    parameter int FLOOR    = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    output logic [CODE_W-1:0] code,
    output logic              done
);
    localparam int STEPS  = 1 << CODE_W;
    localparam int FULL   = STEPS - 1;
    localparam int SPAN   = FULL - FLOOR;
    localparam int IDX_W  = CODE_W + 1;
    localparam int PRE_W  = $clog2(STEP_CYC + 1);
    localparam int PROD_W = IDX_W + CODE_W;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(STEP_CYC - 1);
    localparam logic [IDX_W-1:0] IDX_END  = IDX_W'(STEPS);

    logic [PRE_W-1:0] pre;
    logic [IDX_W-1:0] idx;

    assign done = (idx == IDX_END);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre <= '0;
            idx <= '0;
        end else if (clear) begin
            pre <= '0;
            idx <= '0;
        end else if (advance && !done) begin
            if (pre == PRE_LAST) begin
                pre <= '0;
                idx <= idx + 1'b1;
            end else begin
                pre <= pre + 1'b1;
            end
        end
    end

    // R3: the step index never passes the end of the ramp
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= IDX_END);

    generate
        if (DESCEND) begin : g_down
            logic [PROD_W-1:0] prod;
            logic [IDX_W-1:0]  drop;
            assign prod = PROD_W'(idx) * PROD_W'(SPAN);
            assign drop = IDX_W'(prod >> CODE_W);
            assign code = CODE_W'(IDX_W'(FULL) - drop);

            // R4: descending code stays at or above the floor
            a_r4_floor: assert property (@(posedge clk) disable iff (!rst_n)
                code >= CODE_W'(FLOOR));
            // R4: without a clear the code never rises
            a_r4_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
                !clear |=> code <= $past(code));
        end else begin : g_up
            assign code = done ? CODE_W'(FULL) : idx[CODE_W-1:0];

            // R3: without a clear the code never falls
            a_r3_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
                !clear |=> code >= $past(code));
        end
    endgenerate

endmodule

// File: rtl/ss_delay.sv
module ss_delay #(
    parameter int COUNT = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(COUNT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(COUNT - 1);

    logic [CNT_W-1:0] cnt;

    assign expired = run && (cnt == CNT_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6: the delay count stays inside its window
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_LAST);

    // R8: outside the delay phase the count returns to zero
    a_r8_count_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt == '0);

endmodule

// File: rtl/softstart_sequencer.sv
module softstart_sequencer
    import ss_seq_pkg::*;
#(
    parameter int CODE_W    = 7,
    parameter int CLK_KHZ   = 125000,
    parameter int BOOST_MS  = 10,
    parameter int GATE_MS   = 3,
    parameter int DELAY_CYC = 2500000,
    parameter int FLOOR     = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              ref_ok,
    input  logic              fault_latched,
    input  logic              sw_sel,
    output logic              boost_en,
    output logic              gon_en,
    output logic              goff_en,
    output logic [CODE_W-1:0] boost_code,
    output logic [CODE_W-1:0] gon_code,
    output logic [CODE_W-1:0] goff_code,
    output logic              ss_active,
    output logic              sw_enable,
    output logic              com_to_a,
    output logic              com_to_b,
    output logic              amp_hiz
);
    localparam int STEPS      = 1 << CODE_W;
    localparam int FULL       = STEPS - 1;
    localparam int BOOST_STEP = (CLK_KHZ * BOOST_MS) / STEPS;
    localparam int GATE_STEP  = (CLK_KHZ * GATE_MS) / STEPS;

    function automatic int step_of(input int i);
        return (i == 0) ? BOOST_STEP : GATE_STEP;
    endfunction

    seq_state_t state, state_nx;

    logic [CODE_W-1:0]    raw_code [NUM_RAMPS];
    logic [NUM_RAMPS-1:0] done_vec;
    logic                 ramp_clear;
    logic                 ramp_adv;
    logic                 all_done;
    logic                 delay_run;
    logic                 delay_expired;
    logic                 regs_on;

    assign ramp_clear = (state == ST_OFF);
    assign ramp_adv   = (state == ST_RAMP);
    assign delay_run  = (state == ST_DELAY);
    assign all_done   = &done_vec;

    generate
        for (genvar g = 0; g < NUM_RAMPS; g++) begin : g_ramp
            ss_ramp #(
                .CODE_W  (CODE_W),
                .STEP_CYC(step_of(g) < 1 ? 1 : step_of(g)),
                .DESCEND (g == 2),
                .FLOOR   (FLOOR)
            ) u_ramp (
                .clk    (clk),
                .rst_n  (rst_n),
                .clear  (ramp_clear),
                .advance(ramp_adv),
                .code   (raw_code[g]),
                .done   (done_vec[g])
            );
        end
    endgenerate

    ss_delay #(
        .COUNT(DELAY_CYC < 1 ? 1 : DELAY_CYC)
    ) u_delay (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (delay_run),
        .expired(delay_expired)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF: begin
                if (supply_ok && ref_ok && !fault_latched) state_nx = ST_RAMP;
            end
            ST_RAMP: begin
                if (!supply_ok)         state_nx = ST_OFF;
                else if (fault_latched) state_nx = ST_FAULT;
                else if (all_done)      state_nx = ST_DELAY;
            end
            ST_DELAY: begin
                if (!supply_ok)         state_nx = ST_OFF;
                else if (fault_latched) state_nx = ST_FAULT;
                else if (delay_expired) state_nx = ST_RUN;
            end
            ST_RUN: begin
                if (!supply_ok)         state_nx = ST_OFF;
                else if (fault_latched) state_nx = ST_FAULT;
            end
            ST_FAULT: begin
                if (!supply_ok)         state_nx = ST_OFF;
            end
            default: state_nx = ST_OFF;
        endcase
    end

    always_comb begin
        regs_on    = (state == ST_RAMP) || (state == ST_DELAY) || (state == ST_RUN);
        boost_en   = regs_on;
        gon_en     = regs_on;
        goff_en    = regs_on;
        boost_code = regs_on ? raw_code[0] : '0;
        gon_code   = regs_on ? raw_code[1] : '0;
        goff_code  = regs_on ? raw_code[2] : CODE_W'(FULL);
        ss_active  = (state == ST_RAMP);
        sw_enable  = (state == ST_RUN);
        com_to_a   = sw_enable && sw_sel;
        com_to_b   = sw_enable && !sw_sel;
        amp_hiz    = (state == ST_OFF) || (state == ST_FAULT);
    end

    // R1: enables only rise after a qualified start
    a_r1_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(boost_en) |-> $past(supply_ok && ref_ok && !fault_latched));

    // R2: ramps begin from their starting codes
    a_r2_start_codes: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(boost_en) |-> (boost_code == '0 && gon_code == '0
                             && goff_code == CODE_W'(FULL)));

    // R6: switch release only after every ramp is finished
    a_r6_after_ramps: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_enable) |-> all_done);

    // R7: the common node is never tied to both sources
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(com_to_a && com_to_b));

    // R8: loss of supply shuts the outputs down
    a_r8_supply_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!boost_en && !sw_enable && amp_hiz));

    // R10: a latched fault shuts the outputs down
    a_r10_fault_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
        fault_latched |=> (!boost_en && !gon_en && !goff_en && !sw_enable));

endmodule

// File: tb/softstart_sequencer_bench.sv
module softstart_sequencer_bench;

    localparam int CLK_KHZ = 128;
    localparam int STEP_B  = 10;
    localparam int STEP_G  = 3;
    localparam int DLY     = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic ref_ok = 1'b0;
    logic fault_latched = 1'b0;
    logic sw_sel = 1'b0;
    logic boost_en, gon_en, goff_en, ss_active, sw_enable, com_to_a, com_to_b, amp_hiz;
    logic [6:0] boost_code, gon_code, goff_code;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    softstart_sequencer #(
        .CODE_W(7), .CLK_KHZ(CLK_KHZ), .BOOST_MS(10), .GATE_MS(3),
        .DELAY_CYC(DLY), .FLOOR(26)
    ) u_softstart_sequencer (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ref_ok(ref_ok),
        .fault_latched(fault_latched), .sw_sel(sw_sel),
        .boost_en(boost_en), .gon_en(gon_en), .goff_en(goff_en),
        .boost_code(boost_code), .gon_code(gon_code), .goff_code(goff_code),
        .ss_active(ss_active), .sw_enable(sw_enable),
        .com_to_a(com_to_a), .com_to_b(com_to_b), .amp_hiz(amp_hiz)
    );

    // behavioural reference model: 0 off, 1 ramp, 2 delay, 3 run, 4 fault
    int mst = 0;
    int el = 0;
    int dc = 0;

    function automatic int kidx(input int n, input int step);
        int k;
        k = n / step;
        return (k > 128) ? 128 : k;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mst = 0; el = 0; dc = 0;
        end else begin
            case (mst)
                0: begin
                    el = 0; dc = 0;
                    if (supply_ok && ref_ok && !fault_latched) mst = 1;
                end
                1: begin
                    if (!supply_ok) mst = 0;
                    else if (fault_latched) mst = 4;
                    else if (kidx(el, STEP_B) == 128 && kidx(el, STEP_G) == 128) mst = 2;
                    else el++;
                end
                2: begin
                    if (!supply_ok) mst = 0;
                    else if (fault_latched) mst = 4;
                    else if (dc == DLY - 1) mst = 3;
                    else dc++;
                end
                3: begin
                    if (!supply_ok) mst = 0;
                    else if (fault_latched) mst = 4;
                end
                default: begin
                    if (!supply_ok) mst = 0;
                end
            endcase
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit on;
        int kb, kg, eb, eg, eo;
        on = (mst >= 1 && mst <= 3);
        kb = kidx(el, STEP_B);
        kg = kidx(el, STEP_G);
        eb = on ? ((kb > 127) ? 127 : kb) : 0;
        eg = on ? ((kg > 127) ? 127 : kg) : 0;
        eo = on ? (127 - (kg * 101) / 128) : 127;
        chk("R2 enables", {boost_en, gon_en, goff_en}, on ? 7 : 0);
        chk("R3 boost_code", boost_code, eb);
        chk("R3 gon_code", gon_code, eg);
        chk("R4 goff_code", goff_code, eo);
        chk("R9 ss_active", ss_active, mst == 1);
        chk("R6 sw_enable", sw_enable, mst == 3);
        chk("R7 com", {com_to_a, com_to_b},
            (mst == 3) ? (sw_sel ? 2 : 1) : 0);
        chk("R8 amp_hiz", amp_hiz, (mst == 0 || mst == 4));
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_all();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R8 reset amp_hiz", amp_hiz, 1);
        chk("R2 reset goff idle", goff_code, 127);
        rst_n = 1'b1;
        tick(2);

        // R1: supply good but reference not good
        supply_ok = 1'b1; ref_ok = 1'b0;
        tick(20);
        chk("R1 no start without ref", boost_en, 0);
        // R1: fault latched blocks start
        ref_ok = 1'b1; fault_latched = 1'b1;
        tick(20);
        chk("R1 no start with fault", boost_en, 0);

        // normal start
        fault_latched = 1'b0;
        tick(1);
        chk("R2 first codes", {boost_code, gon_code, goff_code}, {7'd0, 7'd0, 7'd127});
        tick(30);
        chk("R5 boost step 10", boost_code, 3);
        chk("R5 gate step 3", gon_code, 10);
        chk("R4 goff at k10", goff_code, 120);
        tick(1300);
        chk("R6 switch on", sw_enable, 1);
        chk("R4 goff floor", goff_code, 26);
        chk("R3 boost full", boost_code, 127);
        sw_sel = 1'b1;
        tick(3);
        chk("R7 to a", {com_to_a, com_to_b}, 2);
        sw_sel = 1'b0;
        tick(3);
        chk("R7 to b", {com_to_a, com_to_b}, 1);

        // R8: supply drop in run
        supply_ok = 1'b0;
        tick(3);
        chk("R8 drop hiz", amp_hiz, 1);
        chk("R8 drop sw", sw_enable, 0);

        // R8: drop during delay then restart: delay must restart from zero
        supply_ok = 1'b1;
        tick(1281 + 1 + 10);
        supply_ok = 1'b0;
        tick(2);
        supply_ok = 1'b1;
        tick(1 + 1281 + DLY - 1);
        chk("R8 delay restarted", sw_enable, 0);
        tick(1);
        chk("R6 delay expiry", sw_enable, 1);

        // R10: fault in run
        fault_latched = 1'b1;
        tick(2);
        chk("R10 fault off", boost_en, 0);
        fault_latched = 1'b0;
        tick(60);
        chk("R10 frozen", {boost_en, sw_enable, amp_hiz}, 1);
        supply_ok = 1'b0;
        tick(2);
        supply_ok = 1'b1;
        tick(200);
        // R10: fault during ramp
        fault_latched = 1'b1;
        tick(2);
        chk("R10 ramp fault", {gon_en, ss_active}, 0);
        fault_latched = 1'b0;
        tick(100);
        chk("R10 no self restart", boost_en, 0);
        supply_ok = 1'b0;
        tick(2);
        supply_ok = 1'b1;
        tick(1400);
        chk("R10 restart after cycling", sw_enable, 1);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule